// File: doc/BRIEF.md
# Direction-Bit Replay Rotation CORDIC

This block is the last step of a polar-form complex divider. An earlier vectoring CORDIC rotated the divisor onto the real axis and recorded one decision bit per micro-rotation. This block takes a fixed-point vector (u, v), usually the dividend parts already divided by the scaled divisor radius, and turns it back through the divisor's angle. It uses those recorded bits directly. It keeps no angle register and no arctangent constants. Each stage reads its bit and picks one of two shift-and-add rotations.

Twenty-one micro-rotations are unrolled. A pipeline register follows every fourth stage, so the block accepts one operand per clock and returns the result six clocks later. The bit vector enters with its operand and moves down the pipeline with it. The outputs carry the usual rotation gain of about 1.64676. The upstream division by the scaled radius already holds the matching 1/K factor, so the two cancel. Making the bits and removing the gain both belong to neighbouring blocks.

Top module: `crot_replay_rotator`

## Requirements
- R1: `out_vld` equals `in_vld` delayed by exactly 6 clocks, which is the number of 4-stage groups needed for 21 stages. Operands may be given on every clock and each one yields one result.
- R2: Reset is synchronous and active low. A clock edge with `rst_n` low clears the valid pipeline and sets `out_u`/`out_v` to 0.
- R3: Bit i of `in_dir` controls stage i, and stage 0 runs first. With bit value 1 the stage rotates clockwise: x += y>>>i and y -= x>>>i. With bit value 0 it rotates counter-clockwise: x -= y>>>i and y += x>>>i. Both updates use the stage's input values.
- R4: Data words are 27-bit two's complement with 1 sign bit, 2 integer bits and 24 fraction bits. Shifts are arithmetic and truncate toward minus infinity. Sums wrap at 27 bits. The output matches this arithmetic bit for bit.
- R5: While `out_vld` is low, `out_u` and `out_v` keep the value of the last result, or 0 after reset.
- R6: A zero input vector gives a zero output whatever the bits are.
- R7: With all bits 0 the vector turns counter-clockwise by the sum of atan(2^-i) over i = 0..20 (about 99.88 degrees) and is scaled by the product of sqrt(1+2^-2i). With all bits 1 it turns the same amount clockwise. Each output part is within 1e-5 of the real-valued result when |u|, |v| <= 1.5.
- R8: Each result depends only on the bit vector sampled together with its own operand. Bits presented on other clocks, including clocks with `in_vld` low, have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Operand valid |
| in_u | input | 27 | Real part of the vector to rotate, signed 1.2.24 |
| in_v | input | 27 | Imaginary part of the vector to rotate, signed 1.2.24 |
| in_dir | input | 21 | Recorded direction bits, bit i for stage i |
| out_vld | output | 1 | Result valid |
| out_u | output | 27 | Rotated real part, gain K included |
| out_v | output | 27 | Rotated imaginary part, gain K included |

## Verification
Accepting a new operand and its bit vector can happen in the same clock as a result for an older operand leaving the last group. Bits for other operands are then sitting in every register in between. The bench provokes this with long runs of back-to-back random operands. Each operand has its own random bit vector, and random bits are also driven on idle clocks. Every emerging result is compared with a bench model evaluated on the bits captured with that operand, in the clock six edges later. A reset in the middle of a full pipeline is used to check that clearing happens in the same edge as the input traffic.

// File: rtl/crot_pkg.sv
// Shared definitions for the direction-bit replay rotator.
// Assumes: nothing beyond IEEE 1800-2017 elaboration.
package crot_pkg;

    // Rotation sense selected by one recorded direction bit.
    typedef enum logic {
        ROT_CCW = 1'b0,
        ROT_CW  = 1'b1
    } rot_dir_e;

    // Number of register groups needed to hold m stages, n per group.
    function automatic int group_count(input int m, input int n);
        return (m + n - 1) / n;
    endfunction

endpackage

// File: rtl/crot_stage.sv
// One unrolled circular micro-rotation by +/- atan(2^-SH).
// Assumes: operands are two's complement, SH < W; purely combinational.
// Subtraction uses inverted operand plus carry-in; shifts are sign-extending wiring.
module crot_stage
    import crot_pkg::*;
#(
    parameter int W  = 27,
    parameter int SH = 0
) (
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    input  logic                cw,
    output logic signed [W-1:0] x_o,
    output logic signed [W-1:0] y_o
);

    logic signed [W-1:0] x_sh;
    logic signed [W-1:0] y_sh;
    logic                sub_x;
    logic                sub_y;

    // Add a and b, or a and the one's complement of b plus carry when sub is set.
    function automatic logic signed [W-1:0] addsub(
        input logic signed [W-1:0] a,
        input logic signed [W-1:0] b,
        input logic                sub
    );
        logic [W-1:0] opnd;
        opnd = sub ? ~b : b;
        return a + opnd + W'(sub);
    endfunction

    // Shifted copies of the stage inputs.
    assign x_sh = x_i >>> SH;
    assign y_sh = y_i >>> SH;

    // Clockwise: x adds, y subtracts; counter-clockwise: the reverse.
    assign sub_x = (cw != ROT_CW);
    assign sub_y = (cw == ROT_CW);

    // Cross-coupled update of both channels.
    always_comb begin
        x_o = addsub(x_i, y_sh, sub_x);
        y_o = addsub(y_i, x_sh, sub_y);
    end

endmodule

// File: rtl/crot_group.sv
// N consecutive micro-rotations followed by one pipeline register.
// Group GI covers stages GI*N .. GI*N+N-1; stage slots past M-1 pass data through.
// Assumes: dir_i bit k drives stage k; data registers load only on valid.
module crot_group #(
    parameter int W  = 27,
    parameter int M  = 21,
    parameter int N  = 4,
    parameter int GI = 0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic [M-1:0]        dir_i,
    input  logic signed [W-1:0] x_i,
    input  logic signed [W-1:0] y_i,
    output logic                vld_q,
    output logic [M-1:0]        dir_q,
    output logic signed [W-1:0] x_q,
    output logic signed [W-1:0] y_q
);

    logic signed [W-1:0] xc [0:N];
    logic signed [W-1:0] yc [0:N];

    assign xc[0] = x_i;
    assign yc[0] = y_i;

    // Unrolled stage chain; slots beyond the last stage are wires.
    for (genvar k = 0; k < N; k++) begin : g_slot
        localparam int IDX = GI * N + k;
        if (IDX < M) begin : g_rot
            crot_stage #(.W(W), .SH(IDX)) u_stage (
                .x_i (xc[k]),
                .y_i (yc[k]),
                .cw  (dir_i[IDX]),
                .x_o (xc[k+1]),
                .y_o (yc[k+1])
            );
        end else begin : g_pass
            assign xc[k+1] = xc[k];
            assign yc[k+1] = yc[k];
        end
    end

    // Pipeline register: valid always advances, payload loads with valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            dir_q <= '0;
            x_q   <= '0;
            y_q   <= '0;
        end else begin
            vld_q <= vld_i;
            if (vld_i) begin
                dir_q <= dir_i;
                x_q   <= xc[N];
                y_q   <= yc[N];
            end
        end
    end

    // R1: valid moves exactly one group per clock.
    a_r1_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (vld_q == $past(vld_i)));

    // R8: the bit vector travels unchanged with its operand.
    a_r8_dir_travels: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vld_i)) |-> (dir_q == $past(dir_i)));

    // R6: a zero vector stays zero through the group.
    a_r6_zero_in_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(vld_i) && $past(x_i) == '0 && $past(y_i) == '0)
        |-> (x_q == '0 && y_q == '0));

endmodule

// File: rtl/crot_replay_rotator.sv
// Rotation CORDIC that replays recorded vectoring decisions, one bit per stage.
// Assumes: |u|,|v| small enough that K*|(u,v)| stays below 4 (no wrap);
// the result carries gain K; latency is group_count(M,N) clocks.
module crot_replay_rotator #(
    parameter int W = 27,
    parameter int M = 21,
    parameter int N = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic signed [W-1:0] in_u,
    input  logic signed [W-1:0] in_v,
    input  logic [M-1:0]        in_dir,
    output logic                out_vld,
    output logic signed [W-1:0] out_u,
    output logic signed [W-1:0] out_v
);

    localparam int G = crot_pkg::group_count(M, N);

    logic                vld_c [0:G];
    logic [M-1:0]        dir_c [0:G];
    logic signed [W-1:0] x_c   [0:G];
    logic signed [W-1:0] y_c   [0:G];
    logic                dir_tail_unused;

    assign vld_c[0] = in_vld;
    assign dir_c[0] = in_dir;
    assign x_c[0]   = in_u;
    assign y_c[0]   = in_v;

    // Chain of register groups, each holding N stages.
    for (genvar g = 0; g < G; g++) begin : g_grp
        crot_group #(.W(W), .M(M), .N(N), .GI(g)) u_grp (
            .clk   (clk),
            .rst_n (rst_n),
            .vld_i (vld_c[g]),
            .dir_i (dir_c[g]),
            .x_i   (x_c[g]),
            .y_i   (y_c[g]),
            .vld_q (vld_c[g+1]),
            .dir_q (dir_c[g+1]),
            .x_q   (x_c[g+1]),
            .y_q   (y_c[g+1])
        );
    end

    // Outputs come straight from the last group register.
    assign out_vld = vld_c[G];
    assign out_u   = x_c[G];
    assign out_v   = y_c[G];
    assign dir_tail_unused = ^dir_c[G];

    // R5: result pair holds while no new result is presented.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !out_vld) |-> ($stable(out_u) && $stable(out_v)));

    // R2: a reset edge leaves the output valid low.
    a_r2_reset_clear: assert property (@(posedge clk)
        $past(!rst_n) |-> !out_vld);

endmodule

// File: tb/crot_replay_rotator_test.sv
module crot_replay_rotator_test;
    localparam int W   = 27;
    localparam int M   = 21;
    localparam int N   = 4;
    localparam int LAT = (M + N - 1) / N;
    localparam int ONE = 1 << 24;
    localparam int LIM = 25165824;   // 1.5 in 1.2.24

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_vld = 1'b0;
    logic signed [W-1:0] in_u = '0;
    logic signed [W-1:0] in_v = '0;
    logic [M-1:0] in_dir = '0;
    logic out_vld;
    logic signed [W-1:0] out_u;
    logic signed [W-1:0] out_v;

    always #4 clk = ~clk;

    crot_replay_rotator #(.W(W), .M(M), .N(N)) uut (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_u(in_u), .in_v(in_v),
        .in_dir(in_dir), .out_vld(out_vld), .out_u(out_u), .out_v(out_v)
    );

    int checks = 0;
    int fails = 0;
    int n = 0;
    bit done = 1'b0;
    logic                rv [0:15];
    logic signed [W-1:0] rx [0:15];
    logic signed [W-1:0] ry [0:15];
    logic signed [W-1:0] last_x = '0;
    logic signed [W-1:0] last_y = '0;

    // Bit-exact reference per R3/R4.
    function automatic logic [2*W-1:0] model(input logic signed [W-1:0] u,
                                             input logic signed [W-1:0] v,
                                             input logic [M-1:0] d);
        logic signed [W-1:0] x, y, tx, ty;
        x = u; y = v;
        for (int i = 0; i < M; i++) begin
            tx = x >>> i;
            ty = y >>> i;
            if (d[i]) begin x = x + ty; y = y - tx; end
            else      begin x = x - ty; y = y + tx; end
        end
        return {x, y};
    endfunction

    task automatic chk(input string req, input string what, input bit ok,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // One clock: compare the output due now, then drive the next input.
    task automatic step(input logic v, input logic signed [W-1:0] u,
                        input logic signed [W-1:0] w, input logic [M-1:0] d);
        logic [2*W-1:0] e;
        int k;
        @(negedge clk);
        if (n >= LAT) begin
            k = (n - LAT) % 16;
            chk("R1", "out_vld", out_vld == rv[k], longint'(out_vld), longint'(rv[k]));
            if (rv[k]) begin
                // R3 R4 R8: exact match with bits captured for this operand
                chk("R4", "out_u", out_u == rx[k], longint'(out_u), longint'(rx[k]));
                chk("R8", "out_v", out_v == ry[k], longint'(out_v), longint'(ry[k]));
                last_x = rx[k];
                last_y = ry[k];
            end else begin
                chk("R5", "hold u", out_u == last_x, longint'(out_u), longint'(last_x));
                chk("R5", "hold v", out_v == last_y, longint'(out_v), longint'(last_y));
            end
        end
        in_vld = v; in_u = u; in_v = w; in_dir = d;
        e = model(u, w, d);
        rv[n % 16] = v;
        rx[n % 16] = e[2*W-1:W];
        ry[n % 16] = e[W-1:0];
        n++;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        in_vld = 1'b0;
        repeat (2) @(negedge clk);
        chk("R2", "out_vld in reset", out_vld == 1'b0, longint'(out_vld), 0);
        chk("R2", "out_u in reset", out_u == '0, longint'(out_u), 0);
        chk("R2", "out_v in reset", out_v == '0, longint'(out_v), 0);
        rst_n = 1'b1;
        n = 0;
        last_x = '0;
        last_y = '0;
    endtask

    function automatic logic signed [W-1:0] rnd_val();
        return W'(int'($urandom_range(2 * LIM, 0)) - LIM);
    endfunction

    // R7: apply one vector with uniform bits and compare with real rotation.
    task automatic approx(input real u, input real v, input bit cw);
        real a, kg, c, s, xe, ye, xa, ya;
        a = 0.0; kg = 1.0;
        for (int i = 0; i < M; i++) begin
            a = a + $atan(2.0 ** (-i));
            kg = kg * $sqrt(1.0 + 2.0 ** (-2 * i));
        end
        if (cw) a = -a;
        c = $cos(a); s = $sin(a);
        xe = kg * (u * c - v * s);
        ye = kg * (u * s + v * c);
        step(1'b1, W'($rtoi(u * ONE)), W'($rtoi(v * ONE)), cw ? '1 : '0);
        for (int i = 0; i < LAT; i++) step(1'b0, '0, '0, '0);
        xa = $itor(out_u) / ONE;
        ya = $itor(out_v) / ONE;
        checks++;
        if ((xa - xe > 1e-5) || (xe - xa > 1e-5) || (ya - ye > 1e-5) || (ye - ya > 1e-5)) begin
            fails++;
            $display("FAIL R7 rotation: actual (%f,%f) expected (%f,%f)", xa, ya, xe, ye);
        end
    endtask

    initial begin
        void'($urandom(32'h5eed_0c0d));
        for (int i = 0; i < 16; i++) begin rv[i] = 1'b0; rx[i] = '0; ry[i] = '0; end
        do_reset();
        // R7 directed: uniform direction bits
        approx(1.0, 0.0, 1'b0);
        approx(0.0, 1.2, 1'b1);
        approx(-1.5, 1.5, 1'b0);
        // R6: zero vector with random bits
        step(1'b1, '0, '0, M'($urandom));
        step(1'b1, '0, '0, '1);
        // corners at the range limits
        step(1'b1, W'(LIM), W'(LIM), '0);
        step(1'b1, -W'(LIM), -W'(LIM), '1);
        step(1'b1, W'(LIM), -W'(LIM), M'(21'h155555));
        // R1 R8: back-to-back random stream, bits random also on idle clocks
        for (int i = 0; i < 3000; i++)
            step(($urandom_range(9, 0) < 8), rnd_val(), rnd_val(), M'($urandom));
        // R2: reset with a full pipeline, then resume
        do_reset();
        for (int i = 0; i < 500; i++)
            step(1'b1, rnd_val(), rnd_val(), M'($urandom));
        for (int i = 0; i < LAT + 2; i++) step(1'b0, '0, '0, M'($urandom));
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule